// File: doc/BRIEF.md
# Code-Masked Counter State Register

This block is an 8-bit up-counter whose flip-flops never hold the plain count. The register keeps a 16-bit word z = xG ⊕ yH over GF(2). Here x is the logical count, G generates a binary linear code C, and H generates the dual of C. The 8-bit mask y is taken fresh from an external random port on every clock edge. Any small group of stored bits is therefore blinded by the mask, and the stored pattern changes on every cycle, including cycles where the count does not move.

The count is read back from z only through the projection matrix J = Gᵀ(GGᵀ)⁻¹. The next-count logic works on that decoded value. A selector picks one of three named choices: SEL_ZERO on reset, SEL_HOLD when counting is disabled, and SEL_INC otherwise. The chosen value is re-encoded with G, masked with the new random word through H, and written back. Every vector-matrix product is an XOR of the matrix rows picked out by the set bits of the input vector. G, H and J are packed parameters.

The default matrices use G = [I | 1] and H = [1 | I], where 1 is the all-ones 8×8 block. With these defaults GGᵀ = I and HHᵀ = I, so J = Gᵀ.

Top module: `code_masked_counter`

## Requirements
- R1: A synchronous reset writes an encoded word whose decoded count is 0. Reset takes priority over the count enable.
- R2: With reset low and the count enable high, the decoded count rises by exactly one per clock edge.
- R3: The count wraps from 255 to 0 on an enabled edge.
- R4: With reset low and the count enable low, the decoded count keeps its value across the edge.
- R5: After every edge, the stored word equals xG ⊕ yH, where y is the random input sampled at that edge. With the default matrices the mask can be recovered from the stored word: mask bit j = state bit 8+j XOR the parity of state bits 7..0.
- R6: The count output equals the stored word projected through J. With the default matrices, count bit i = state bit i XOR the parity of state bits 15..8.
- R7: On a hold cycle whose random input differs from the previous one, the stored word changes while the decoded count does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| cnt_en_i | input | 1 | Count enable |
| rnd_i | input | 8 | Fresh random mask word, sampled on every edge |
| count_o | output | 8 | Decoded count, zJ |
| state_o | output | 16 | Raw encoded and masked register word |

## Verification
The checker assumes that reset is asserted before any counting property is evaluated. It also assumes the random port holds a defined value at every edge, because the mask-recovery property compares the stored word with the previous random input. The bench asserts reset from time zero and drives every input on the falling edge, so each sampled value is stable and known. Because the mask-recovery formula relies on the default matrices, the bench and the checker elaborate only with the default parameters.

// File: rtl/cmc_pkg.sv
package cmc_pkg;

    typedef enum logic [1:0] {
        SEL_ZERO = 2'd0,
        SEL_HOLD = 2'd1,
        SEL_INC  = 2'd2
    } next_sel_e;

    // Default code: G = [I | ones], H = [ones | I]; both GG^T and HH^T are identity.
    localparam int DEF_K = 8;
    localparam int DEF_N = 16;

    localparam logic [DEF_K*DEF_N-1:0] DEF_G = {
        16'hFF80, 16'hFF40, 16'hFF20, 16'hFF10,
        16'hFF08, 16'hFF04, 16'hFF02, 16'hFF01
    };

    localparam logic [DEF_K*DEF_N-1:0] DEF_H = {
        16'h80FF, 16'h40FF, 16'h20FF, 16'h10FF,
        16'h08FF, 16'h04FF, 16'h02FF, 16'h01FF
    };

    // J = G^T (GG^T)^-1 = G^T for the defaults; row m is the x-contribution of z bit m.
    localparam logic [DEF_N*DEF_K-1:0] DEF_J = {
        8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF,
        8'h80, 8'h40, 8'h20, 8'h10, 8'h08, 8'h04, 8'h02, 8'h01
    };

    // K = H^T (HH^T)^-1 = H^T for the defaults; used by the checker only.
    localparam logic [DEF_N*DEF_K-1:0] DEF_K_MAT = {
        8'h80, 8'h40, 8'h20, 8'h10, 8'h08, 8'h04, 8'h02, 8'h01,
        8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF
    };

endpackage

// File: rtl/cmc_gf2_vecmat.sv
module cmc_gf2_vecmat #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 16,
    parameter logic [IN_W*OUT_W-1:0] MAT = '0
) (
    input  logic [IN_W-1:0]  vec_i,
    output logic [OUT_W-1:0] prod_o
);

    logic [OUT_W-1:0] acc [IN_W+1];

    assign acc[0] = '0;

    for (genvar r = 0; r < IN_W; r++) begin : g_row
        assign acc[r+1] = acc[r] ^ (vec_i[r] ? MAT[r*OUT_W +: OUT_W] : {OUT_W{1'b0}});
    end

    assign prod_o = acc[IN_W];

endmodule

// File: rtl/cmc_encoder.sv
module cmc_encoder #(
    parameter int K_W = 8,
    parameter int N_W = 16,
    parameter logic [K_W*N_W-1:0]       G_MAT = '0,
    parameter logic [(N_W-K_W)*N_W-1:0] H_MAT = '0
) (
    input  logic [K_W-1:0]     data_i,
    input  logic [N_W-K_W-1:0] mask_i,
    output logic [N_W-1:0]     word_o
);

    localparam int M_W = N_W - K_W;

    logic [N_W-1:0] data_cw;
    logic [N_W-1:0] mask_cw;

    cmc_gf2_vecmat #(.IN_W(K_W), .OUT_W(N_W), .MAT(G_MAT)) u_data_enc (
        .vec_i  (data_i),
        .prod_o (data_cw)
    );

    cmc_gf2_vecmat #(.IN_W(M_W), .OUT_W(N_W), .MAT(H_MAT)) u_mask_enc (
        .vec_i  (mask_i),
        .prod_o (mask_cw)
    );

    assign word_o = data_cw ^ mask_cw;

endmodule

// File: rtl/code_masked_counter.sv
module code_masked_counter
    import cmc_pkg::*;
#(
    parameter int K_W = DEF_K,
    parameter int N_W = DEF_N,
    parameter logic [K_W*N_W-1:0]       G_MAT = DEF_G,
    parameter logic [(N_W-K_W)*N_W-1:0] H_MAT = DEF_H,
    parameter logic [N_W*K_W-1:0]       J_MAT = DEF_J
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               cnt_en_i,
    input  logic [N_W-K_W-1:0] rnd_i,
    output logic [K_W-1:0]     count_o,
    output logic [N_W-1:0]     state_o
);

    logic [N_W-1:0] z_q;
    logic [N_W-1:0] z_next;
    logic [K_W-1:0] x_dec;
    logic [K_W-1:0] x_next;
    next_sel_e      sel;

    // Projection z -> x: the only path from stored state to plain count.
    cmc_gf2_vecmat #(.IN_W(N_W), .OUT_W(K_W), .MAT(J_MAT)) u_decode (
        .vec_i  (z_q),
        .prod_o (x_dec)
    );

    always_comb begin
        if (rst_i)         sel = SEL_ZERO;
        else if (cnt_en_i) sel = SEL_INC;
        else               sel = SEL_HOLD;
    end

    always_comb begin
        unique case (sel)
            SEL_ZERO: x_next = '0;
            SEL_HOLD: x_next = x_dec;
            SEL_INC:  x_next = x_dec + K_W'(1);
            default:  x_next = '0;
        endcase
    end

    cmc_encoder #(.K_W(K_W), .N_W(N_W), .G_MAT(G_MAT), .H_MAT(H_MAT)) u_encode (
        .data_i (x_next),
        .mask_i (rnd_i),
        .word_o (z_next)
    );

    always_ff @(posedge clk_i) begin
        z_q <= z_next;
    end

    assign count_o = x_dec;
    assign state_o = z_q;

endmodule

// File: rtl/code_masked_counter_chk.sv
module code_masked_counter_chk
    import cmc_pkg::*;
#(
    parameter int K_W = DEF_K,
    parameter int N_W = DEF_N,
    parameter logic [N_W*(N_W-K_W)-1:0] K_MAT = DEF_K_MAT
) (
    input logic               clk_i,
    input logic               rst_i,
    input logic               cnt_en_i,
    input logic [N_W-K_W-1:0] rnd_i,
    input logic [K_W-1:0]     count_o,
    input logic [N_W-1:0]     state_o
);

    localparam int M_W = N_W - K_W;

    logic           armed;
    logic [M_W-1:0] mask_rec;

    always_ff @(posedge clk_i) begin
        if (rst_i) armed <= 1'b1;
    end

    always_comb begin
        mask_rec = '0;
        for (int m = 0; m < N_W; m++) begin
            if (state_o[m]) mask_rec = mask_rec ^ K_MAT[m*M_W +: M_W];
        end
    end

    AST_RESET_ZERO: assert property (@(posedge clk_i)
        rst_i |=> count_o == '0); // R1

    AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (rst_i || armed !== 1'b1)
        cnt_en_i |=> count_o == K_W'($past(count_o) + K_W'(1))); // R2

    AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (rst_i || armed !== 1'b1)
        (cnt_en_i && count_o == {K_W{1'b1}}) |=> count_o == '0); // R3

    AST_HOLD_COUNT: assert property (@(posedge clk_i) disable iff (rst_i || armed !== 1'b1)
        !cnt_en_i |=> $stable(count_o)); // R4

    AST_MASK_FRESH: assert property (@(posedge clk_i)
        1'b1 |=> mask_rec == $past(rnd_i)); // R5

endmodule

bind code_masked_counter code_masked_counter_chk #(.K_W(K_W), .N_W(N_W)) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .cnt_en_i (cnt_en_i),
    .rnd_i    (rnd_i),
    .count_o  (count_o),
    .state_o  (state_o)
);

// File: tb/code_masked_counter_tb_top.sv
`timescale 1ns/1ps
module code_masked_counter_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        en;
    logic [7:0]  rnd;
    logic [7:0]  count;
    logic [15:0] state;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    code_masked_counter dut_i (
        .clk_i    (clk),
        .rst_i    (rst),
        .cnt_en_i (en),
        .rnd_i    (rnd),
        .count_o  (count),
        .state_o  (state)
    );

    function automatic logic [7:0] dec_x(input logic [15:0] z);
        return z[7:0] ^ {8{^z[15:8]}};
    endfunction

    function automatic logic [7:0] dec_y(input logic [15:0] z);
        return z[15:8] ^ {8{^z[7:0]}};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic e, input logic [7:0] m);
        @(negedge clk);
        rst = r; en = e; rnd = m;
        @(posedge clk);
        #1;
    endtask

    // {rst, en, rnd, expected count}
    localparam logic [17:0] VEC [12] = '{
        {1'b1, 1'b0, 8'h5A, 8'd0},
        {1'b0, 1'b1, 8'h3C, 8'd1},
        {1'b0, 1'b1, 8'hFF, 8'd2},
        {1'b0, 1'b0, 8'h00, 8'd2},
        {1'b0, 1'b0, 8'h81, 8'd2},
        {1'b0, 1'b1, 8'h7E, 8'd3},
        {1'b0, 1'b1, 8'h01, 8'd4},
        {1'b1, 1'b1, 8'hC3, 8'd0},
        {1'b0, 1'b1, 8'h99, 8'd1},
        {1'b0, 1'b0, 8'h99, 8'd1},
        {1'b0, 1'b1, 8'h10, 8'd2},
        {1'b0, 1'b1, 8'hE7, 8'd3}
    };

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0]  ref_cnt;
        logic [7:0]  lfsr;
        logic [15:0] prev_state;
        rst = 1'b1; en = 1'b0; rnd = 8'h00;

        // Vector table: R1 reset (incl. priority over enable), R2 step, R4 hold, R5 mask, R6 decode
        for (int i = 0; i < 12; i++) begin
            step(VEC[i][17], VEC[i][16], VEC[i][15:8]);
            check("R2/R4/R1 count", count, VEC[i][7:0]);
            check("R6 decode", dec_x(state), VEC[i][7:0]);
            check("R5 mask", dec_y(state), VEC[i][15:8]);
        end

        // Directed: reset then full wrap with varying masks (R2, R3, R6, R5)
        step(1'b1, 1'b0, 8'hA5);
        check("R1 reset count", count, 8'd0);
        ref_cnt = 8'd0;
        lfsr = 8'h1D;
        for (int i = 0; i < 260; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step(1'b0, 1'b1, lfsr);
            ref_cnt = ref_cnt + 8'd1;
            if (count !== ref_cnt || dec_x(state) !== ref_cnt || dec_y(state) !== lfsr) begin
                check("R2 sweep count", count, ref_cnt);
                check("R6 sweep decode", dec_x(state), ref_cnt);
                check("R5 sweep mask", dec_y(state), lfsr);
            end
            if (ref_cnt == 8'd0) check("R3 wrap to zero", count, 8'd0);
        end
        check("R2 sweep final", count, ref_cnt);

        // Hold with fresh masks: count stays, word changes (R7, R4)
        step(1'b0, 1'b0, 8'h11);
        prev_state = state;
        for (int i = 0; i < 4; i++) begin
            step(1'b0, 1'b0, 8'h11 + 8'(i + 1) * 8'h22);
            check("R4 hold count", count, ref_cnt);
            check("R7 word changes", (state != prev_state) ? 32'd1 : 32'd0, 32'd1);
            prev_state = state;
        end

        // Count to 255 then wrap directly (R3)
        step(1'b1, 1'b0, 8'h00);
        for (int i = 0; i < 255; i++) step(1'b0, 1'b1, 8'(i));
        check("R3 at max", count, 8'hFF);
        step(1'b0, 1'b1, 8'h6B);
        check("R3 wrap", count, 8'h00);
        check("R5 wrap mask", dec_y(state), 8'h6B);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule